// File: doc/BRIEF.md
# Receive Character Buffer with Delivery Timeout

This block sits between a serial receiver, which has already recovered and checked each character, and the host register view. Every character arrives as a one-cycle push of a data byte plus three error tags (parity, framing, break). Each entry holds the byte and its tags together, in a queue of up to 32 entries. The oldest entry is shown to the host as a read-only holding byte. A read strobe removes it, and the next entry, with its own tags, appears at once.

A data-ready interrupt is raised in one of two ways: on every character, or only when the fill reaches a selectable trigger level. A delivery timeout makes sure that a partly filled queue still reaches the host. It counts ticks at sixteen times the bit rate, and when no character has arrived and no read has happened for (4 × word length + 12) bit times, it raises the interrupt. With queueing disabled, the block acts as a single holding byte.

Top module: `rx_char_buffer`

## Requirements
- R1: After reset the fill is 0, status_o is all zero, and irq_o and timeout_o are low.
- R2: With queueing enabled, up to 32 entries are held. The holding byte shows them oldest first, and each accepted push or read changes fill_o by one.
- R3: status_o[4:2] show the head entry's tags (bit 2 parity, bit 3 framing, bit 4 break) and change in the same cycle as the holding byte after a read. They are 0 when the buffer is empty.
- R4: status_o[0] (data ready) is 1 exactly when the fill is non-zero.
- R5: A push into a full buffer without a read in the same cycle is discarded and sets status_o[1] (overrun). The bit stays set until a status read strobe, and a new overrun in the same cycle wins over that strobe.
- R6: A push and a read in the same cycle on a non-empty buffer leave the fill unchanged.
- R7: With queueing disabled the capacity is one entry. Any change of the queue-enable input empties the buffer on the next clock.
- R8: In per-character mode (trig_mode_i=0), the data-ready request is active whenever the fill is non-zero.
- R9: In level mode (trig_mode_i=1), the request is active while fill ≥ level, with trig_sel_i 0,1,2,3 giving 1, 8, 16 and 28 entries. In single-byte mode the level is 1.
- R10: timeout_o rises after (32 + 4·word_len_i)·16 tick cycles during which the buffer held data with no push and no read. Each push or read restarts the count.
- R11: timeout_o is cleared by a host read, and while high it drives irq_o regardless of the fill.
- R12: irq_o is the data-ready request or timeout, gated by ie_rx_i. It is low when ie_rx_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Received character strobe |
| push_data_i | input | 8 | Received byte |
| push_tags_i | input | 3 | Tags: bit0 parity, bit1 framing, bit2 break |
| fifo_en_i | input | 1 | 1 = 32-entry queue, 0 = single holding byte |
| trig_mode_i | input | 1 | 0 = per character, 1 = trigger level |
| trig_sel_i | input | 2 | Trigger level select |
| word_len_i | input | 2 | Word length minus 5 |
| ie_rx_i | input | 1 | Receive interrupt enable |
| tick16_i | input | 1 | 16x bit-rate tick |
| rd_data_i | input | 1 | Host read of the holding byte |
| rd_status_i | input | 1 | Host read of status, clears overrun |
| hold_data_o | output | 8 | Head byte |
| status_o | output | 5 | {break, framing, parity, overrun, ready} |
| fill_o | output | 6 | Entries held |
| timeout_o | output | 1 | Delivery timeout pending |
| irq_o | output | 1 | Receive interrupt |

## Verification
Push, read and status-clear effects are registered once, so they are due at the first clock edge after the strobe. The bench drives every strobe on a falling edge and compares results on the next falling edge. Holding byte, tags and interrupt follow the fill combinationally, so they share that timing. Timeout is registered on the tick that completes the window. After a push, the bench therefore waits exactly limit−1 falling edges and checks for low, then one more and checks for high.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tags_t;

  typedef struct packed {
    rx_tags_t   tags;
    logic [7:0] data;
  } rx_entry_t;

  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - depth / 8;
    endcase
  endfunction
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              single_i,
  input  logic              push_i,
  input  rx_entry_t         entry_i,
  input  logic              pop_i,
  output rx_entry_t         head_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              full_o,
  output logic              push_ok_o,
  output logic              pop_ok_o,
  output logic              drop_o
);
  rx_entry_t         mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [FILL_W-1:0] fill_q, cap;

  assign cap       = single_i ? FILL_W'(1) : FILL_W'(DEPTH);
  assign full_o    = fill_q >= cap;
  assign pop_ok_o  = pop_i && (fill_q != '0);
  assign push_ok_o = push_i && (!full_o || pop_ok_o);
  assign drop_o    = push_i && !push_ok_o;
  assign head_o    = mem_q[rd_q];
  assign fill_o    = fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else if (flush_i) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push_ok_o) wr_q <= wr_q + PTR_W'(1);
      if (pop_ok_o)  rd_q <= rd_q + PTR_W'(1);
      case ({push_ok_o, pop_ok_o})
        2'b10:   fill_q <= fill_q + FILL_W'(1);
        2'b01:   fill_q <= fill_q - FILL_W'(1);
        default: fill_q <= fill_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok_o && !flush_i) mem_q[wr_q] <= entry_i;
  end

  p_fill_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_W'(DEPTH));
  p_single_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_i && !flush_i) |-> fill_q <= FILL_W'(1));
  p_pushpop_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && fill_q != '0 && !flush_i) |=> fill_q == $past(fill_q));
  p_drop_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o && !flush_i) |=> fill_q == $past(fill_q));
endmodule

// File: rtl/rxbuf_timeout.sv
module rxbuf_timeout #(
  parameter int unsigned TICKS_PER_BIT = 16,
  localparam int unsigned CNT_W = $clog2(44 * TICKS_PER_BIT + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] word_len_i,
  input  logic       active_i,
  input  logic       restart_i,
  input  logic       clear_i,
  output logic       flag_o
);
  logic [CNT_W-1:0] cnt_q, limit;
  logic             flag_q;

  // (4 * (5 + wl) + 12) bit times
  assign limit  = CNT_W'((32 + 4 * int'(word_len_i)) * TICKS_PER_BIT);
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (!active_i || restart_i)    cnt_q <= '0;
      else if (tick_i && cnt_q < limit) cnt_q <= cnt_q + CNT_W'(1);

      if (clear_i) flag_q <= 1'b0;
      else if (active_i && !restart_i && tick_i && cnt_q == limit - CNT_W'(1)) flag_q <= 1'b1;
    end
  end

  p_tmo_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !flag_q);
  p_tmo_needs_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> active_i);
endmodule

// File: rtl/rxbuf_irq.sv
module rxbuf_irq
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic [FILL_W-1:0] fill_i,
  input  logic              single_i,
  input  logic              level_mode_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              tmo_i,
  input  logic              ie_i,
  output logic              irq_o
);
  logic [FILL_W-1:0] level;
  logic              data_req;

  assign level    = single_i ? FILL_W'(1) : FILL_W'(trig_level(trig_sel_i, DEPTH));
  assign data_req = level_mode_i ? (fill_i >= level) : (fill_i != '0);
  assign irq_o    = ie_i && (data_req || tmo_i);
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH         = 32,
  parameter int unsigned TICKS_PER_BIT = 16,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [7:0]        push_data_i,
  input  logic [2:0]        push_tags_i,
  input  logic              fifo_en_i,
  input  logic              trig_mode_i,
  input  logic [1:0]        trig_sel_i,
  input  logic [1:0]        word_len_i,
  input  logic              ie_rx_i,
  input  logic              tick16_i,
  input  logic              rd_data_i,
  input  logic              rd_status_i,
  output logic [7:0]        hold_data_o,
  output logic [4:0]        status_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              timeout_o,
  output logic              irq_o
);
  rx_entry_t         entry, head;
  logic [FILL_W-1:0] fill;
  logic              fifo_en_q, flush, single, full, push_ok, pop_ok, drop, tmo;
  logic              overrun_q, ready;

  assign entry  = '{tags: rx_tags_t'(push_tags_i), data: push_data_i};
  assign flush  = fifo_en_i != fifo_en_q;
  assign single = !fifo_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      fifo_en_q <= fifo_en_i;
      overrun_q <= drop || (overrun_q && !rd_status_i);
    end
  end

  rxbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .flush_i   (flush),
    .single_i  (single),
    .push_i    (push_i),
    .entry_i   (entry),
    .pop_i     (rd_data_i),
    .head_o    (head),
    .fill_o    (fill),
    .full_o    (full),
    .push_ok_o (push_ok),
    .pop_ok_o  (pop_ok),
    .drop_o    (drop)
  );

  rxbuf_timeout #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_tmo (
    .clk_i, .rst_ni,
    .tick_i     (tick16_i),
    .word_len_i (word_len_i),
    .active_i   (fill != '0),
    .restart_i  (push_ok || pop_ok || flush),
    .clear_i    (pop_ok || flush),
    .flag_o     (tmo)
  );

  rxbuf_irq #(.DEPTH(DEPTH)) u_irq (
    .fill_i       (fill),
    .single_i     (single),
    .level_mode_i (trig_mode_i),
    .trig_sel_i   (trig_sel_i),
    .tmo_i        (tmo),
    .ie_i         (ie_rx_i),
    .irq_o        (irq_o)
  );

  assign ready       = fill != '0;
  assign hold_data_o = head.data;
  assign status_o    = {ready ? head.tags : 3'b000, overrun_q, ready};
  assign fill_o      = fill;
  assign timeout_o   = tmo;

  p_ovr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !rd_data_i && !flush) |=> status_o[1]);
  p_ready_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_rx_i && !trig_mode_i && fill_o != '0) |-> irq_o);
  p_irq_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_rx_i |-> !irq_o);
  p_tmo_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_rx_i && timeout_o) |-> irq_o);
endmodule

// File: tb/rx_char_buffer_test.sv
module rx_char_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic       clk = 0, rst_n = 0;
  logic       push = 0, fifo_en = 1, trig_mode = 1, ie = 1, tick = 0, rd_data = 0, rd_status = 0;
  logic [7:0] pdata = 0;
  logic [2:0] ptags = 0;
  logic [1:0] trig_sel = 0, word_len = 0;
  logic [7:0] hold;
  logic [4:0] status;
  logic [5:0] fill;
  logic       tmo, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_char_buffer uut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(pdata), .push_tags_i(ptags),
    .fifo_en_i(fifo_en), .trig_mode_i(trig_mode), .trig_sel_i(trig_sel), .word_len_i(word_len),
    .ie_rx_i(ie), .tick16_i(tick), .rd_data_i(rd_data), .rd_status_i(rd_status),
    .hold_data_o(hold), .status_o(status), .fill_o(fill), .timeout_o(tmo), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] d, input logic [2:0] t);
    push = 1; pdata = d; ptags = t;
    @(negedge clk);
    push = 0;
  endtask

  task automatic pop_byte();
    rd_data = 1;
    @(negedge clk);
    rd_data = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int level_of(input int sel);
    case (sel)
      0: return 1;
      1: return DEPTH / 4;
      2: return DEPTH / 2;
      default: return DEPTH - DEPTH / 8;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int sel, input int n);
    return 8'((n * 37 + sel * 11 + 5) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 fill", int'(fill), 0);
    check("R1 status", int'(status), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 timeout", int'(tmo), 0);
    rst_n = 1;
    idle(2);
    check("R1 fill after release", int'(fill), 0);

    // R2 R3 R4 R5 R9: full sweep of fill levels for every trigger select
    for (int sel = 0; sel < 4; sel++) begin
      trig_sel = 2'(sel);
      for (int n = 0; n < DEPTH; n++) begin
        push_byte(pat(sel, n), 3'(n % 8));
        check("R2 fill up", int'(fill), n + 1);
        check("R4 ready", int'(status[0]), 1);
        check("R9 level irq", int'(irq), int'((n + 1) >= level_of(sel)));
      end
      push_byte(8'hEE, 3'd7);
      check("R5 full drop fill", int'(fill), DEPTH);
      check("R5 overrun set", int'(status[1]), 1);
      idle(1);
      check("R5 overrun sticky", int'(status[1]), 1);
      rd_status = 1; @(negedge clk); rd_status = 0;
      check("R5 overrun cleared", int'(status[1]), 0);
      for (int n = 0; n < DEPTH; n++) begin
        check("R2 order", int'(hold), int'(pat(sel, n)));
        check("R3 head tags", int'(status[4:2]), n % 8);
        check("R9 irq drain", int'(irq), int'((DEPTH - n) >= level_of(sel)));
        pop_byte();
      end
      check("R2 drained", int'(fill), 0);
      check("R4 not ready", int'(status[0]), 0);
      check("R3 empty tags", int'(status[4:2]), 0);
    end

    // R5: new overrun wins over simultaneous status read
    for (int n = 0; n < DEPTH; n++) push_byte(8'(n), 3'd0);
    push = 1; rd_status = 1; @(negedge clk); push = 0; rd_status = 0;
    check("R5 set wins", int'(status[1]), 1);
    // R6 at full: push and read together keep fill, accept the byte
    push = 1; pdata = 8'hA5; ptags = 3'd5; rd_data = 1;
    @(negedge clk); push = 0; rd_data = 0;
    check("R6 full pushpop fill", int'(fill), DEPTH);
    check("R6 head advanced", int'(hold), 1);
    rd_status = 1; @(negedge clk); rd_status = 0;
    for (int n = 0; n < DEPTH - 1; n++) pop_byte();
    check("R6 last is new byte", int'(hold), 8'hA5);
    check("R3 last tags", int'(status[4:2]), 5);
    pop_byte();

    // R6 partial fill
    push_byte(8'h10, 3'd1); push_byte(8'h11, 3'd2); push_byte(8'h12, 3'd4);
    push = 1; pdata = 8'h13; ptags = 3'd0; rd_data = 1;
    @(negedge clk); push = 0; rd_data = 0;
    check("R6 fill kept", int'(fill), 3);
    check("R3 tags on pop", int'(status[4:2]), 2);

    // R8 R12: per-character mode and enable gating
    trig_mode = 0; trig_sel = 2'd3;
    idle(1);
    check("R8 per char irq", int'(irq), 1);
    ie = 0; idle(1);
    check("R12 gated", int'(irq), 0);
    ie = 1;

    // R7: toggling enable flushes
    fifo_en = 0; idle(1);
    check("R7 flush", int'(fill), 0);
    check("R8 empty no irq", int'(irq), 0);
    push_byte(8'h55, 3'd3);
    push_byte(8'h66, 3'd0);
    check("R7 single cap", int'(fill), 1);
    check("R7 single overrun", int'(status[1]), 1);
    check("R7 keeps first", int'(hold), 8'h55);
    trig_mode = 1; idle(1);
    check("R9 single level one", int'(irq), 1);
    pop_byte();
    check("R7 single empty", int'(fill), 0);
    rd_status = 1; fifo_en = 1; @(negedge clk); rd_status = 0;
    idle(1);

    // R10 R11: timeout per word length
    trig_mode = 1; trig_sel = 2'd1; tick = 1;
    for (int wl = 0; wl < 4; wl++) begin
      automatic int lim = (32 + 4 * wl) * 16;
      word_len = 2'(wl);
      push_byte(8'(wl), 3'd0);
      idle(lim - 1);
      check("R10 not yet", int'(tmo), 0);
      check("R11 irq quiet", int'(irq), 0);
      idle(1);
      check("R10 timeout", int'(tmo), 1);
      check("R11 timeout irq", int'(irq), 1);
      pop_byte();
      check("R11 cleared by read", int'(tmo), 0);
      check("R11 irq cleared", int'(irq), 0);
    end

    // R10: restart on push
    word_len = 2'd0;
    push_byte(8'h01, 3'd0);
    idle(300);
    push_byte(8'h02, 3'd0);
    idle(511);
    check("R10 restarted", int'(tmo), 0);
    idle(1);
    check("R10 after restart", int'(tmo), 1);
    pop_byte();
    check("R11 read clears", int'(tmo), 0);
    idle(511);
    check("R10 restart on read", int'(tmo), 0);
    idle(1);
    check("R10 after read window", int'(tmo), 1);
    pop_byte();
    tick = 0;
    check("R4 final empty", int'(status[0]), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule